// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit sits between an interrupt message receiver and a processor core. Each incoming request carries an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary requests (fixed and lowest-priority) are queued in a 256-entry request array, and a trigger-mode array records how each one was signalled. The special modes do not use the arrays. They each set a pending flag with a latched vector: system-management, non-maskable and init are unmaskable, and the external-controller mode is maskable.

Toward the core the unit presents one pending indication, the chosen vector and a source code. A core interrupt-enable input gates everything except the unmaskable sources. An 8-bit task priority gates the queued vectors. When the core acknowledges, the presented source is consumed. An acknowledged queued vector moves into a 256-entry in-service array. An end-of-interrupt strobe retires the highest in-service vector. Combinational priority encoders track the highest requested vector and the highest in-service vector. Each encoder reports zero when its array is empty.

Top module: `irq_accept_unit`

## Requirements
- R1: A request with mode 0 or 1 sets the request bit of its vector. The trigger bit of that vector is written only if the request bit was clear before: 1 when `req_level` is high, 0 when it is low. `svc_level` shows the trigger bit of the highest in-service vector.
- R2: Mode 2 (SMI), mode 4 (NMI) and mode 5 (INIT) each set their own pending flag and latch the vector. This happens only when that flag is clear. A repeat request while the flag is set is dropped.
- R3: Mode 7 (external controller) sets a maskable pending flag and latches the vector, with the same latch-once rule. Modes 3 and 6 change nothing.
- R4: While any unmaskable flag is set, `irq_pending` is high whatever the value of `core_int_en`.
- R5: With no unmaskable flag set, `irq_pending` is high only while `core_int_en` is high. The external source is presented first (`irq_kind`=2). A queued vector is presented (`irq_kind`=1) only if the highest requested vector exceeds the highest in-service vector and its bits 7:4 exceed `task_prio` bits 7:4. `irq_vector` and `irq_kind` are 0 when nothing is pending.
- R6: The unmaskable sources are presented and served in the order SMI (`irq_kind`=3), then NMI (4), then INIT (5). An acknowledge clears only the flag that was presented.
- R7: Acknowledging a queued vector sets its in-service bit and clears its request bit. The next-highest request then becomes the candidate.
- R8: `eoi` clears the highest in-service bit. `svc_vector` then shows the next-highest in-service vector, or 0 if none is left.
- R9: After reset nothing is pending, and `irq_vector`, `irq_kind`, `svc_vector` and `svc_level` are 0.
- R10: `ack` while `irq_pending` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Incoming request strobe |
| req_vector | input | 8 | Request vector |
| req_mode | input | 3 | Delivery mode code |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| core_int_en | input | 1 | Core maskable-interrupt enable |
| task_prio | input | 8 | Task priority; bits 7:4 are the class |
| ack | input | 1 | Core takes the presented interrupt |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| irq_pending | output | 1 | An interrupt is presented |
| irq_vector | output | 8 | Presented vector |
| irq_kind | output | 3 | Presented source: 0 none, 1 queued, 2 external, 3 SMI, 4 NMI, 5 INIT |
| svc_vector | output | 8 | Highest in-service vector |
| svc_level | output | 1 | Trigger bit of that vector |

## Verification
Requests, acknowledges and end-of-interrupt strobes are sampled on a rising edge, and their results appear at the outputs straight after that same edge. Changes on `core_int_en` and `task_prio` act within the cycle, with no register in the path. The bench drives inputs one nanosecond after a rising edge. It advances its behavioural model on the rising edge and compares every output on the falling edge. Directed checks sample one nanosecond after the edge that consumed the stimulus.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSV3   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSV6   = 3'd6,
        DM_EXT    = 3'd7
    } dmode_e;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_FIXED = 3'd1,
        SRC_EXT   = 3'd2,
        SRC_SMI   = 3'd3,
        SRC_NMI   = 3'd4,
        SRC_INIT  = 3'd5
    } src_e;

    // special slots, in service order; the last one is maskable
    localparam int SLOT_SMI   = 0;
    localparam int SLOT_NMI   = 1;
    localparam int SLOT_INIT  = 2;
    localparam int SLOT_EXT   = 3;
    localparam int NUM_SLOTS  = 4;
    localparam int NUM_UNMASK = 3;

    function automatic dmode_e slot_mode(input int s);
        case (s)
            SLOT_SMI:  return DM_SMI;
            SLOT_NMI:  return DM_NMI;
            SLOT_INIT: return DM_INIT;
            default:   return DM_EXT;
        endcase
    endfunction

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N = 256,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec_in,
    output logic [W-1:0] top_idx
);
    // highest set bit wins; empty input reports zero
    always_comb begin
        top_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec_in[i]) top_idx = W'(i);
        end
    end
endmodule

// File: rtl/irq_vec_arrays.sv
module irq_vec_arrays #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_vec,
    input  logic             set_level,
    input  logic             ack_en,
    input  logic             eoi_en,
    output logic [VEC_W-1:0] irr_top,
    output logic [VEC_W-1:0] isr_top,
    output logic             isr_top_level
);
    localparam int NV = 1 << VEC_W;

    typedef struct packed {
        logic [NV-1:0] req;
        logic [NV-1:0] isr;
        logic [NV-1:0] trg;
    } arr_t;

    arr_t st_d, st_q;

    irq_prio_enc #(.N(NV), .W(VEC_W)) u_irr_enc (
        .vec_in (st_q.req),
        .top_idx(irr_top)
    );

    irq_prio_enc #(.N(NV), .W(VEC_W)) u_isr_enc (
        .vec_in (st_q.isr),
        .top_idx(isr_top)
    );

    assign isr_top_level = st_q.trg[isr_top] & st_q.isr[isr_top];

    always_comb begin
        st_d = st_q;
        if (set_en) begin
            if (!st_q.req[set_vec]) st_d.trg[set_vec] = set_level;
            st_d.req[set_vec] = 1'b1;
        end
        if (ack_en) begin
            st_d.req[irr_top] = 1'b0;
            st_d.isr[irr_top] = 1'b1;
        end
        if (eoi_en) begin
            st_d.isr[isr_top] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: a repeat request leaves the trigger bit alone
    a_r1_trigger_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && st_q.req[set_vec]) |=> (st_q.trg[$past(set_vec)] == $past(st_q.trg[set_vec])));

    // R7: an acknowledged vector moves from request to in-service
    a_r7_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |=> (st_q.isr[$past(irr_top)] && !st_q.req[$past(irr_top)]));

    // R8: end of interrupt retires the top in-service bit
    a_r8_eoi_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_en && (|st_q.isr)) |=> !st_q.isr[$past(isr_top)]);

endmodule

// File: rtl/irq_special_flags.sv
module irq_special_flags
    import irq_accept_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              req_valid,
    input  dmode_e                            req_mode,
    input  logic [VEC_W-1:0]                  req_vec,
    input  logic [NUM_SLOTS-1:0]              ack_slot,
    output logic [NUM_SLOTS-1:0]              pend,
    output logic [NUM_SLOTS-1:0][VEC_W-1:0]   vec
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0]            pend;
        logic [NUM_SLOTS-1:0][VEC_W-1:0] vec;
    } flg_t;

    flg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (req_valid && (req_mode == slot_mode(s)) && !st_q.pend[s]) begin
                st_d.pend[s] = 1'b1;
                st_d.vec[s]  = req_vec;
            end
            if (ack_slot[s]) st_d.pend[s] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign vec  = st_q.vec;

    // R6: at most one source is served per acknowledge
    a_r6_one_served: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_slot));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        // R2: a latched vector holds while its flag stays set
        a_r2_vector_held: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.pend[g] && !ack_slot[g]) |=> (st_q.pend[g] && st_q.vec[g] == $past(st_q.vec[g])));
        // R6: the served flag is cleared
        a_r6_served_clears: assert property (@(posedge clk) disable iff (!rst_n)
            ack_slot[g] |=> !st_q.pend[g]);
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_accept_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic [NUM_SLOTS-1:0]            pend,
    input  logic [NUM_SLOTS-1:0][VEC_W-1:0] vec,
    input  logic [VEC_W-1:0]                irr_top,
    input  logic [VEC_W-1:0]                isr_top,
    input  logic [VEC_W-1:0]                tpr,
    input  logic                            int_en,
    output logic                            sel_valid,
    output logic [VEC_W-1:0]                sel_vec,
    output logic [2:0]                      sel_kind,
    output logic [NUM_SLOTS-1:0]            sel_slot,
    output logic                            sel_fixed
);
    localparam int SUB_W = VEC_W - CLASS_W;
    localparam logic [VEC_W-1:0] SUB_ONES = VEC_W'((1 << SUB_W) - 1);

    logic fixed_ok;
    logic done;

    // class compare: low sub-class bits forced equal on both sides
    assign fixed_ok = (irr_top > isr_top) && ((irr_top | SUB_ONES) > (tpr | SUB_ONES));

    always_comb begin
        sel_valid = 1'b0;
        sel_vec   = '0;
        sel_kind  = SRC_NONE;
        sel_slot  = '0;
        sel_fixed = 1'b0;
        done      = 1'b0;
        for (int s = 0; s < NUM_UNMASK; s++) begin
            if (pend[s] && !done) begin
                done        = 1'b1;
                sel_valid   = 1'b1;
                sel_vec     = vec[s];
                sel_kind    = 3'(SRC_SMI) + 3'(s);
                sel_slot[s] = 1'b1;
            end
        end
        if (!done && int_en) begin
            if (pend[SLOT_EXT]) begin
                sel_valid          = 1'b1;
                sel_vec            = vec[SLOT_EXT];
                sel_kind           = SRC_EXT;
                sel_slot[SLOT_EXT] = 1'b1;
            end else if (fixed_ok) begin
                sel_valid = 1'b1;
                sel_vec   = irr_top;
                sel_kind  = SRC_FIXED;
                sel_fixed = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic [2:0]       req_mode,
    input  logic             req_level,
    input  logic             core_int_en,
    input  logic [VEC_W-1:0] task_prio,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq_pending,
    output logic [VEC_W-1:0] irq_vector,
    output logic [2:0]       irq_kind,
    output logic [VEC_W-1:0] svc_vector,
    output logic             svc_level
);
    dmode_e                          mode;
    logic                            set_fixed;
    logic [NUM_SLOTS-1:0]            pend;
    logic [NUM_SLOTS-1:0][VEC_W-1:0] vec;
    logic [VEC_W-1:0]                irr_top;
    logic [VEC_W-1:0]                isr_top;
    logic [NUM_SLOTS-1:0]            sel_slot;
    logic                            sel_fixed;
    logic                            take;
    logic [NUM_SLOTS-1:0]            ack_slot;
    logic                            ack_fixed;
    logic                            unmask_pend;

    assign mode        = dmode_e'(req_mode);
    assign set_fixed   = req_valid && (mode == DM_FIXED || mode == DM_LOWEST);
    assign take        = ack && irq_pending;
    assign ack_slot    = take ? sel_slot : '0;
    assign ack_fixed   = take && sel_fixed;
    assign unmask_pend = |pend[NUM_UNMASK-1:0];
    assign svc_vector  = isr_top;

    irq_vec_arrays #(.VEC_W(VEC_W)) u_arrays (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_en       (set_fixed),
        .set_vec      (req_vector),
        .set_level    (req_level),
        .ack_en       (ack_fixed),
        .eoi_en       (eoi),
        .irr_top      (irr_top),
        .isr_top      (isr_top),
        .isr_top_level(svc_level)
    );

    irq_special_flags #(.VEC_W(VEC_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_mode (mode),
        .req_vec  (req_vector),
        .ack_slot (ack_slot),
        .pend     (pend),
        .vec      (vec)
    );

    irq_arbiter #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_arb (
        .pend     (pend),
        .vec      (vec),
        .irr_top  (irr_top),
        .isr_top  (isr_top),
        .tpr      (task_prio),
        .int_en   (core_int_en),
        .sel_valid(irq_pending),
        .sel_vec  (irq_vector),
        .sel_kind (irq_kind),
        .sel_slot (sel_slot),
        .sel_fixed(sel_fixed)
    );

    // R4: unmaskable sources are always signalled
    a_r4_unmask_signalled: assert property (@(posedge clk) disable iff (!rst_n)
        unmask_pend |-> irq_pending);

    // R5: with the core disabled only unmaskable sources may show
    a_r5_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_int_en && !unmask_pend) |-> !irq_pending);

    // R10: an acknowledge with nothing presented leaves the flags unchanged
    a_r10_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_pending && !req_valid) |=> $stable(pend));

endmodule

// File: tb/irq_accept_unit_tb.sv
`timescale 1ns/1ps
module irq_accept_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_vector = '0;
    logic [2:0] req_mode = '0;
    logic       req_level = 1'b0;
    logic       core_int_en = 1'b0;
    logic [7:0] task_prio = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_pending;
    logic [7:0] irq_vector;
    logic [2:0] irq_kind;
    logic [7:0] svc_vector;
    logic       svc_level;

    always #2.5 clk = ~clk;

    irq_accept_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_mode(req_mode), .req_level(req_level), .core_int_en(core_int_en),
        .task_prio(task_prio), .ack(ack), .eoi(eoi), .irq_pending(irq_pending),
        .irq_vector(irq_vector), .irq_kind(irq_kind), .svc_vector(svc_vector),
        .svc_level(svc_level)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R9";
    bit    cmp_on = 1'b0;

    // behavioural model
    bit [255:0] m_req = '0;
    bit [255:0] m_isr = '0;
    bit [255:0] m_trg = '0;
    bit         m_sp [4] = '{default: 1'b0};   // SMI, NMI, INIT, external
    int         m_sv [4] = '{default: 0};

    function automatic int hi(input bit [255:0] a);
        for (int i = 255; i >= 0; i--) if (a[i]) return i;
        return 0;
    endfunction

    function automatic void model_out(output bit p, output int v, output int k);
        int r;
        int s;
        r = hi(m_req);
        s = hi(m_isr);
        p = 1'b0; v = 0; k = 0;
        for (int i = 0; i < 3; i++) begin
            if (m_sp[i]) begin p = 1'b1; v = m_sv[i]; k = 3 + i; return; end
        end
        if (core_int_en) begin
            if (m_sp[3]) begin p = 1'b1; v = m_sv[3]; k = 2; end
            else if (r > s && (r / 16) > (int'(task_prio) / 16)) begin p = 1'b1; v = r; k = 1; end
        end
    endfunction

    function automatic int slot_of(input int mode);
        case (mode)
            2: return 0;
            4: return 1;
            5: return 2;
            7: return 3;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        bit p;
        int v;
        int k;
        int st;
        int sl;
        int rv;
        if (!rst_n) begin
            m_req = '0; m_isr = '0; m_trg = '0;
            for (int i = 0; i < 4; i++) begin m_sp[i] = 1'b0; m_sv[i] = 0; end
        end else begin
            model_out(p, v, k);
            st = hi(m_isr);
            rv = int'(req_vector);
            if (req_valid) begin
                if (req_mode == 3'd0 || req_mode == 3'd1) begin
                    if (!m_req[rv]) m_trg[rv] = req_level;
                    m_req[rv] = 1'b1;
                end else begin
                    sl = slot_of(int'(req_mode));
                    if (sl >= 0 && !m_sp[sl]) begin m_sp[sl] = 1'b1; m_sv[sl] = rv; end
                end
            end
            if (ack && p) begin
                if (k == 1) begin m_req[v] = 1'b0; m_isr[v] = 1'b1; end
                else if (k == 2) m_sp[3] = 1'b0;
                else m_sp[k-3] = 1'b0;
            end
            if (eoi) m_isr[st] = 1'b0;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit p;
        int v;
        int k;
        int st;
        if (cmp_on) begin
            model_out(p, v, k);
            st = hi(m_isr);
            chk("model irq_pending", int'(irq_pending), int'(p));
            chk("model irq_vector", int'(irq_vector), v);
            chk("model irq_kind", int'(irq_kind), k);
            chk("model svc_vector", int'(svc_vector), st);
            chk("model svc_level", int'(svc_level), int'(m_trg[st] & m_isr[st]));
        end
    end

    task automatic cyc(input bit v, input int vec, input int mode, input bit lvl,
                       input bit a, input bit e);
        req_valid = v; req_vector = 8'(vec); req_mode = 3'(mode); req_level = lvl;
        ack = a; eoi = e;
        @(posedge clk); #1;
        req_valid = 1'b0; ack = 1'b0; eoi = 1'b0;
    endtask

    task automatic show(input int p, input int v, input int k);
        chk("irq_pending", int'(irq_pending), p);
        chk("irq_vector", int'(irq_vector), v);
        chk("irq_kind", int'(irq_kind), k);
    endtask

    initial begin
        #(5ns * 150000);
        n_bad++;
        $display("FAIL %s watchdog expired", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;
        cur_req = "R9";
        show(0, 0, 0);
        chk("svc_vector", int'(svc_vector), 0);
        chk("svc_level", int'(svc_level), 0);
        core_int_en = 1'b1; task_prio = 8'h00;

        cur_req = "R1";
        cyc(1, 'h45, 0, 1, 0, 0);
        show(1, 'h45, 1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("svc_vector", int'(svc_vector), 'h45);
        chk("svc_level", int'(svc_level), 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("svc_vector", int'(svc_vector), 0);
        cyc(1, 'h45, 1, 0, 0, 0);
        cyc(1, 'h45, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("svc_level kept edge", int'(svc_level), 0);
        cyc(0, 0, 0, 0, 0, 1);

        cur_req = "R5";
        task_prio = 8'h50;
        cyc(1, 'h52, 0, 0, 0, 0);
        show(0, 0, 0);
        cyc(1, 'h61, 0, 0, 0, 0);
        show(1, 'h61, 1);
        core_int_en = 1'b0; #1;
        show(0, 0, 0);
        core_int_en = 1'b1; #1;

        cur_req = "R3";
        cyc(1, 'h20, 7, 0, 0, 0);
        show(1, 'h20, 2);
        cyc(1, 'h28, 7, 0, 0, 0);
        cyc(1, 'h99, 3, 0, 0, 0);
        cyc(1, 'h98, 6, 0, 0, 0);
        show(1, 'h20, 2);
        cyc(0, 0, 0, 0, 1, 0);
        show(1, 'h61, 1);

        cur_req = "R7";
        cyc(0, 0, 0, 0, 1, 0);
        chk("svc_vector", int'(svc_vector), 'h61);
        show(0, 0, 0);

        cur_req = "R8";
        cyc(1, 'h90, 0, 1, 0, 0);
        show(1, 'h90, 1);
        cyc(0, 0, 0, 0, 1, 0);
        chk("svc_vector", int'(svc_vector), 'h90);
        chk("svc_level", int'(svc_level), 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("svc_vector", int'(svc_vector), 'h61);
        cyc(0, 0, 0, 0, 0, 1);
        chk("svc_vector", int'(svc_vector), 0);
        cur_req = "R5";
        task_prio = 8'h40; #1;
        show(1, 'h52, 1);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);

        cur_req = "R10";
        cyc(1, 'h30, 0, 0, 0, 0);
        show(0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        chk("svc_vector", int'(svc_vector), 0);
        task_prio = 8'h00; #1;
        show(1, 'h30, 1);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);

        cur_req = "R2";
        core_int_en = 1'b0;
        cyc(1, 'h33, 5, 0, 0, 0);
        cyc(1, 'h22, 4, 0, 0, 0);
        cyc(1, 'h11, 2, 0, 0, 0);
        cyc(1, 'h44, 4, 0, 0, 0);
        cur_req = "R4";
        show(1, 'h11, 3);
        cur_req = "R6";
        cyc(0, 0, 0, 0, 1, 0);
        show(1, 'h22, 4);
        cyc(0, 0, 0, 0, 1, 0);
        show(1, 'h33, 5);
        cyc(0, 0, 0, 0, 1, 0);
        show(0, 0, 0);
        core_int_en = 1'b1;

        cur_req = "R7";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom % 16 == 0) core_int_en = ($urandom % 4) != 0;
            if ($urandom % 32 == 0) task_prio = 8'($urandom);
            cyc(($urandom % 3) == 0, int'($urandom % 256), int'($urandom % 8),
                1'($urandom), ($urandom % 3) == 0, ($urandom % 8) == 0);
        end
        cyc(0, 0, 0, 0, 0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule